// File: doc/BRIEF.md
# Configurable-Format Serial Frame Transmitter

This block turns characters into asynchronous serial frames on a single output line. An external enable pulse arrives at sixteen times the bit rate, and the block derives every bit period from it. A six-bit format word sets the number of data bits, the parity mode and the length of the stop period. The stop period is counted in sixteenths of a bit, so besides one and two bits it can also be 9/16 of a bit or one and 9/16 bits.

Characters arrive on a valid/ready handshake. A command word turns the transmitter on and off, aborts the frame in progress, and starts or ends a forced break, which holds the line low. The `busy` output marks a frame in progress. The `idle` output marks a quiet, high line.

Top module: `uart_frame_tx`

## Requirements
- R1: After reset the line is high, `idle` is 1, `busy` is 0 and `s_ready` is 0, because the transmitter starts disabled. The format word resets to 0x34, which is 8 data bits, no parity and one stop bit.
- R2: A frame is a low start bit of 16 ticks, then the data bits with the least significant bit first, each 16 ticks long, then the parity bit if enabled (16 ticks), then a high stop period. `busy` falls when the stop period ends.
- R3: Format bits [5:4] select the number of data bits. Codes 0, 1, 2 and 3 give 5, 6, 7 and 8 bits. Data bits above the selected length are not sent.
- R4: Format bits [1:0] select parity. Code 0 sends no parity bit. Code 1 (odd) makes the count of ones in the data bits plus the parity bit odd. Code 2 (even) makes that count even. Code 3 always sends a 0. Odd and even parity count only the data bits that are sent.
- R5: Format bits [3:2] select the stop period. Codes 0, 1, 2 and 3 give 9, 16, 25 and 32 ticks.
- R6: On a command write, bit 2 enables the transmitter and bit 3 disables it. Disable takes priority when both are set. While the transmitter is disabled, `s_ready` is 0. A frame already under way finishes at its normal length.
- R7: The command field in bits [8:4] starts a break with code 0x5 and ends it with code 0x6. During a break the line is low and `busy`, `idle` and `s_ready` are all 0. If a break is requested during a frame, that frame finishes at full length and the line then goes low.
- R8: Command field code 0x2 aborts any frame or break. On the next clock the line is high, `idle` is 1 and the break request is cleared.
- R9: The format is captured when a character is accepted. A format write during a frame does not alter that frame. The next frame uses the new format.
- R10: `s_ready` is 1 only when the transmitter is enabled, no frame is in progress and no break is requested or active. A character is accepted on a clock where both `s_valid` and `s_ready` are 1. The next clock shows `busy` at 1 and the line low. While `idle` is 1 the line is high.
- R11: Bit timing advances only on clocks where `tick` is 1. Without ticks the line holds its level and the frame stretches by the number of missing ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Oversample enable, 16 per bit time |
| fmt_we | input | 1 | Format word write strobe |
| fmt_wdata | input | 6 | Format word: [5:4] length, [3:2] stop, [1:0] parity |
| cmd_we | input | 1 | Command write strobe |
| cmd_wdata | input | 9 | Command: bit 2 enable, bit 3 disable, [8:4] channel code |
| s_valid | input | 1 | Character offered |
| s_data | input | 8 | Character to send |
| s_ready | output | 1 | Character can be accepted |
| txd | output | 1 | Serial line, idles high |
| busy | output | 1 | Frame in progress |
| idle | output | 1 | No frame and no break, line high |

## Verification
The bench builds the block with its default parameters: 8 data bits at most and 16 ticks per bit. With these, the stop lengths are 9, 16, 25 and 32 ticks, and every format code can be reached. Most tests assert `tick` on every clock, so each bit lasts exactly 16 clocks. The bench can then sample every bit at its centre and check the frame length to the cycle. One test removes ticks for part of a frame to show that the line holds its level and the frame stretches by exactly the missing ticks. The command tests cover these cases:
- a break requested from idle;
- a break requested during a frame;
- an abort during a frame;
- enable and disable written in the same command word.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_START, ST_DATA, ST_PAR, ST_STOP, ST_BRK
  } tx_state_e;

  // Packed MSB first: length [5:4], stop [3:2], parity [1:0]
  typedef struct packed {
    logic [1:0] clen;
    logic [1:0] stop;
    logic [1:0] par;
  } fmt_t;

  localparam fmt_t FMT_RESET = 6'h34;

  localparam logic [1:0] PAR_NONE  = 2'd0;
  localparam logic [1:0] PAR_ODD   = 2'd1;
  localparam logic [1:0] PAR_EVEN  = 2'd2;
  localparam logic [1:0] PAR_SPACE = 2'd3;

  localparam int CMD_EN_BIT  = 2;
  localparam int CMD_DIS_BIT = 3;

  localparam logic [4:0] CH_ABORT  = 5'h02;
  localparam logic [4:0] CH_BRK_ON = 5'h05;
  localparam logic [4:0] CH_BRK_OF = 5'h06;
endpackage

// File: rtl/uart_tx_cmd.sv
module uart_tx_cmd
  import uart_tx_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       fmt_we,
  input  logic [5:0] fmt_wdata,
  input  logic       cmd_we,
  input  logic [8:0] cmd_wdata,
  output fmt_t       fmt_q,
  output logic       tx_en,
  output logic       brk_req,
  output logic       abort
);
  logic [4:0] chan;
  assign chan  = cmd_wdata[8:4];
  assign abort = cmd_we && (chan == CH_ABORT);

  always_ff @(posedge clk) begin
    if (rst) begin
      fmt_q   <= FMT_RESET;
      tx_en   <= 1'b0;
      brk_req <= 1'b0;
    end else begin
      if (fmt_we) fmt_q <= fmt_t'(fmt_wdata);
      if (cmd_we) begin
        if (cmd_wdata[CMD_DIS_BIT])     tx_en <= 1'b0;
        else if (cmd_wdata[CMD_EN_BIT]) tx_en <= 1'b1;
        if (chan == CH_BRK_ON)                        brk_req <= 1'b1;
        else if (chan == CH_BRK_OF || chan == CH_ABORT) brk_req <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/uart_tx_parity.sv
module uart_tx_parity
  import uart_tx_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int BW = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] data,
  input  logic [BW-1:0]     last_idx,
  input  logic [1:0]        par_mode,
  output logic              par_on,
  output logic              par_bit
);
  logic [DATA_W-1:0] mask;

  for (genvar g = 0; g < DATA_W; g++) begin : g_mask
    assign mask[g] = (g <= int'(last_idx));
  end

  logic ones_odd;
  assign ones_odd = ^(data & mask);

  always_comb begin
    par_on = (par_mode != PAR_NONE);
    unique case (par_mode)
      PAR_ODD:  par_bit = ~ones_odd;
      PAR_EVEN: par_bit = ones_odd;
      default:  par_bit = 1'b0;
    endcase
  end
endmodule

// File: rtl/uart_tx_serial.sv
module uart_tx_serial
  import uart_tx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OVS    = 16,
  localparam int BW    = $clog2(DATA_W),
  localparam int CW    = $clog2(2 * OVS),
  localparam int FRAC  = (OVS * 9 + 8) / 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              abort,
  input  logic              brk_req,
  input  logic              load,
  input  logic [DATA_W-1:0] data,
  input  logic [BW-1:0]     last_idx,
  input  logic [1:0]        stop_code,
  input  logic              par_on,
  input  logic              par_bit,
  output tx_state_e         state,
  output logic              txd
);
  logic [CW-1:0]     cnt;
  logic [DATA_W-1:0] shreg;
  logic [BW-1:0]     left;
  logic [1:0]        stop_q;
  logic              par_on_q, par_bit_q;
  logic [CW-1:0]     stop_last;
  logic              bit_end;

  always_comb begin
    unique case (stop_q)
      2'd0:    stop_last = CW'(FRAC - 1);
      2'd1:    stop_last = CW'(OVS - 1);
      2'd2:    stop_last = CW'(OVS + FRAC - 1);
      default: stop_last = CW'(2 * OVS - 1);
    endcase
  end

  assign bit_end = tick && (cnt == CW'(OVS - 1));

  always_ff @(posedge clk) begin
    if (rst || abort) begin
      state     <= ST_IDLE;
      txd       <= 1'b1;
      cnt       <= '0;
      shreg     <= '0;
      left      <= '0;
      stop_q    <= 2'd1;
      par_on_q  <= 1'b0;
      par_bit_q <= 1'b0;
    end else begin
      if (tick && state inside {ST_START, ST_DATA, ST_PAR, ST_STOP})
        cnt <= cnt + 1'b1;
      unique case (state)
        ST_IDLE: begin
          if (brk_req) begin
            state <= ST_BRK;
            txd   <= 1'b0;
          end else if (load) begin
            state     <= ST_START;
            txd       <= 1'b0;
            cnt       <= '0;
            shreg     <= data;
            left      <= last_idx;
            stop_q    <= stop_code;
            par_on_q  <= par_on;
            par_bit_q <= par_bit;
          end
        end
        ST_START: if (bit_end) begin
          cnt   <= '0;
          state <= ST_DATA;
          txd   <= shreg[0];
          shreg <= shreg >> 1;
        end
        ST_DATA: if (bit_end) begin
          cnt <= '0;
          if (left == '0) begin
            state <= par_on_q ? ST_PAR : ST_STOP;
            txd   <= par_on_q ? par_bit_q : 1'b1;
          end else begin
            left  <= left - 1'b1;
            txd   <= shreg[0];
            shreg <= shreg >> 1;
          end
        end
        ST_PAR: if (bit_end) begin
          cnt   <= '0;
          state <= ST_STOP;
          txd   <= 1'b1;
        end
        ST_STOP: if (tick && cnt == stop_last) begin
          cnt   <= '0;
          state <= brk_req ? ST_BRK : ST_IDLE;
          txd   <= !brk_req;
        end
        default: if (!brk_req) begin
          state <= ST_IDLE;
          txd   <= 1'b1;
        end
      endcase
    end
  end
endmodule

// File: rtl/uart_frame_tx.sv
module uart_frame_tx
  import uart_tx_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int OVS      = 16,
  parameter int MIN_BITS = 5,
  localparam int BW      = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              fmt_we,
  input  logic [5:0]        fmt_wdata,
  input  logic              cmd_we,
  input  logic [8:0]        cmd_wdata,
  input  logic              s_valid,
  input  logic [DATA_W-1:0] s_data,
  output logic              s_ready,
  output logic              txd,
  output logic              busy,
  output logic              idle
);
  fmt_t      fmt_q;
  logic      tx_en, brk_req, abort, par_on, par_bit;
  tx_state_e state;
  logic [BW-1:0] last_idx;

  assign last_idx = BW'(MIN_BITS - 1) + BW'(fmt_q.clen);

  uart_tx_cmd u_cmd (
    .clk(clk), .rst(rst), .fmt_we(fmt_we), .fmt_wdata(fmt_wdata),
    .cmd_we(cmd_we), .cmd_wdata(cmd_wdata), .fmt_q(fmt_q),
    .tx_en(tx_en), .brk_req(brk_req), .abort(abort)
  );

  uart_tx_parity #(.DATA_W(DATA_W)) u_par (
    .data(s_data), .last_idx(last_idx), .par_mode(fmt_q.par),
    .par_on(par_on), .par_bit(par_bit)
  );

  uart_tx_serial #(.DATA_W(DATA_W), .OVS(OVS)) u_ser (
    .clk(clk), .rst(rst), .tick(tick), .abort(abort), .brk_req(brk_req),
    .load(s_valid && s_ready), .data(s_data), .last_idx(last_idx),
    .stop_code(fmt_q.stop), .par_on(par_on), .par_bit(par_bit),
    .state(state), .txd(txd)
  );

  assign idle    = (state == ST_IDLE);
  assign busy    = state inside {ST_START, ST_DATA, ST_PAR, ST_STOP};
  assign s_ready = tx_en && idle && !brk_req;
endmodule

// File: rtl/uart_frame_tx_chk.sv
module uart_frame_tx_chk (
  input logic       clk,
  input logic       rst,
  input logic       tick,
  input logic       cmd_we,
  input logic [8:0] cmd_wdata,
  input logic       s_valid,
  input logic       s_ready,
  input logic       txd,
  input logic       busy,
  input logic       idle
);
  assert_reset_line_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (txd && idle && !s_ready));

  assert_accept_start_R10: assert property (@(posedge clk) disable iff (rst)
    (s_valid && s_ready && !cmd_we) |=> (busy && !txd));

  assert_idle_high_R10: assert property (@(posedge clk) disable iff (rst)
    idle |-> txd);

  assert_ready_idle_R10: assert property (@(posedge clk) disable iff (rst)
    s_ready |-> (idle && !busy));

  assert_break_low_R7: assert property (@(posedge clk) disable iff (rst)
    (!busy && !idle) |-> !txd);

  assert_disable_R6: assert property (@(posedge clk) disable iff (rst)
    (cmd_we && cmd_wdata[3]) |=> !s_ready);

  assert_abort_R8: assert property (@(posedge clk) disable iff (rst)
    (cmd_we && cmd_wdata[8:4] == 5'h02) |=> (idle && txd));

  assert_hold_R11: assert property (@(posedge clk) disable iff (rst)
    (busy && !tick && !cmd_we) |=> $stable(txd));
endmodule

bind uart_frame_tx uart_frame_tx_chk u_chk (
  .clk(clk), .rst(rst), .tick(tick), .cmd_we(cmd_we), .cmd_wdata(cmd_wdata),
  .s_valid(s_valid), .s_ready(s_ready), .txd(txd), .busy(busy), .idle(idle)
);

// File: tb/uart_frame_tx_tb.sv
`timescale 1ns/1ps
module uart_frame_tx_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick = 1'b1;
  logic fmt_we = 1'b0;
  logic [5:0] fmt_wdata = '0;
  logic cmd_we = 1'b0;
  logic [8:0] cmd_wdata = '0;
  logic s_valid = 1'b0;
  logic [7:0] s_data = '0;
  logic s_ready, txd, busy, idle;
  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  uart_frame_tx u_dut (
    .clk(clk), .rst(rst), .tick(tick), .fmt_we(fmt_we), .fmt_wdata(fmt_wdata),
    .cmd_we(cmd_we), .cmd_wdata(cmd_wdata), .s_valid(s_valid), .s_data(s_data),
    .s_ready(s_ready), .txd(txd), .busy(busy), .idle(idle)
  );

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic set_fmt(input logic [5:0] v);
    @(negedge clk); fmt_we = 1'b1; fmt_wdata = v;
    @(negedge clk); fmt_we = 1'b0;
  endtask

  task automatic send_cmd(input logic [8:0] v);
    @(negedge clk); cmd_we = 1'b1; cmd_wdata = v;
    @(negedge clk); cmd_we = 1'b0;
  endtask

  task automatic send_char(input logic [7:0] d);
    int guard = 0;
    @(negedge clk);
    while (!s_ready && guard < 1000) begin @(negedge clk); guard++; end
    s_valid = 1'b1; s_data = d;
    @(negedge clk); s_valid = 1'b0;
  endtask

  // Sends one character and checks each bit and the frame length.
  // fmt is the format in effect at acceptance; optional writes at given offsets.
  task automatic run_frame(input logic [7:0] d, input logic [5:0] fmt,
                           input int fw_at, input logic [5:0] fw_val,
                           input int cw_at, input logic [8:0] cw_val,
                           input string tag);
    int nd, np, nb, sl, j, ones;
    logic [11:0] line;
    logic pb;
    nd = 5 + int'(fmt[5:4]);
    np = (fmt[1:0] != 2'd0) ? 1 : 0;
    case (fmt[3:2])
      2'd0: sl = 9;  2'd1: sl = 16;  2'd2: sl = 25;  default: sl = 32;
    endcase
    ones = 0;
    for (int i = 0; i < nd; i++) ones += int'(d[i]);
    case (fmt[1:0])
      2'd1: pb = (ones % 2 == 0);
      2'd2: pb = (ones % 2 == 1);
      default: pb = 1'b0;
    endcase
    line = '1;
    line[0] = 1'b0;
    for (int i = 0; i < nd; i++) line[1 + i] = d[i];
    if (np == 1) line[1 + nd] = pb;
    nb = 1 + nd + np;
    send_char(d);
    check({tag, " R10 busy after accept"}, int'(busy), 1);
    check({tag, " R2 start low"}, int'(txd), 0);
    j = 0;
    while (j < 2000) begin
      @(negedge clk);
      j++;
      if (j == fw_at) begin fmt_we = 1'b1; fmt_wdata = fw_val; end
      if (j == fw_at + 1) fmt_we = 1'b0;
      if (j == cw_at) begin cmd_we = 1'b1; cmd_wdata = cw_val; end
      if (j == cw_at + 1) cmd_we = 1'b0;
      if (j % 16 == 8 && j < 16 * nb)
        check($sformatf("%s R2 bit%0d", tag, j / 16), int'(txd), int'(line[j / 16]));
      if (j == 16 * nb + 4) check({tag, " R2 stop high"}, int'(txd), 1);
      if (!busy) break;
    end
    fmt_we = 1'b0; cmd_we = 1'b0;
    check({tag, " R5 frame length"}, j, 16 * nb + sl);
  endtask

  task automatic t_reset;
    check("R1 line high", int'(txd), 1);
    check("R1 idle", int'(idle), 1);
    check("R1 not busy", int'(busy), 0);
    check("R1 ready low while disabled", int'(s_ready), 0);
    send_cmd(9'h004);
    check("R6 ready after enable", int'(s_ready), 1);
    run_frame(8'h5A, 6'h34, 0, 6'h0, 0, 9'h0, "R1 reset format 8N1");
  endtask

  task automatic t_formats;
    set_fmt(6'h00); run_frame(8'hFD, 6'h00, 0, 6'h0, 0, 9'h0, "R3 5 bits stop9");
    set_fmt(6'h15); run_frame(8'h2C, 6'h15, 0, 6'h0, 0, 9'h0, "R4 6 bits odd");
    set_fmt(6'h2A); run_frame(8'hFF, 6'h2A, 0, 6'h0, 0, 9'h0, "R4 7 bits even stop25");
    set_fmt(6'h3D); run_frame(8'hA5, 6'h3D, 0, 6'h0, 0, 9'h0, "R5 8 bits odd stop32");
    set_fmt(6'h33); run_frame(8'hFF, 6'h33, 0, 6'h0, 0, 9'h0, "R4 space parity");
    set_fmt(6'h01); run_frame(8'hE3, 6'h01, 0, 6'h0, 0, 9'h0, "R3 5 bits odd masked");
    set_fmt(6'h36); run_frame(8'h81, 6'h36, 0, 6'h0, 0, 9'h0, "R4 8 bits even");
  endtask

  task automatic t_enable;
    send_cmd(9'h00C);
    check("R6 disable wins", int'(s_ready), 0);
    send_cmd(9'h004);
    set_fmt(6'h34);
    run_frame(8'h3C, 6'h34, 0, 6'h0, 40, 9'h008, "R6 disable mid-frame");
    check("R6 ready low after disable", int'(s_ready), 0);
    send_cmd(9'h004);
    check("R6 ready after re-enable", int'(s_ready), 1);
  endtask

  task automatic t_break_idle;
    send_cmd(9'h050);
    @(negedge clk);
    check("R7 break line low", int'(txd), 0);
    check("R7 break not idle", int'(idle), 0);
    check("R7 break not busy", int'(busy), 0);
    check("R7 break not ready", int'(s_ready), 0);
    repeat (30) @(negedge clk);
    check("R7 break held", int'(txd), 0);
    send_cmd(9'h060);
    @(negedge clk);
    check("R7 break end line high", int'(txd), 1);
    check("R7 break end idle", int'(idle), 1);
    check("R7 break end ready", int'(s_ready), 1);
  endtask

  task automatic t_break_mid;
    run_frame(8'hC3, 6'h34, 0, 6'h0, 30, 9'h050, "R7 break mid-frame");
    check("R7 low after frame", int'(txd), 0);
    check("R7 not idle after frame", int'(idle), 0);
    send_cmd(9'h060);
    @(negedge clk);
    check("R7 line restored", int'(txd), 1);
  endtask

  task automatic t_abort;
    send_char(8'h00);
    repeat (40) @(negedge clk);
    check("R8 low data before abort", int'(txd), 0);
    send_cmd(9'h020);
    check("R8 abort idle", int'(idle), 1);
    check("R8 abort line high", int'(txd), 1);
    check("R8 abort not busy", int'(busy), 0);
    send_cmd(9'h050);
    @(negedge clk);
    check("R8 break before abort", int'(txd), 0);
    send_cmd(9'h020);
    check("R8 abort clears break", int'(idle), 1);
    @(negedge clk);
    check("R8 break request cleared", int'(txd), 1);
    check("R8 ready after abort", int'(s_ready), 1);
  endtask

  task automatic t_fmt_mid;
    set_fmt(6'h34);
    run_frame(8'hB6, 6'h34, 20, 6'h00, 0, 9'h0, "R9 format write mid-frame");
    run_frame(8'hB6, 6'h00, 0, 6'h0, 0, 9'h0, "R9 new format next frame");
  endtask

  task automatic t_tick;
    int j;
    set_fmt(6'h34);
    send_char(8'hFF);
    repeat (8) @(negedge clk);
    tick = 1'b0;
    repeat (40) @(negedge clk);
    check("R11 line held without ticks", int'(txd), 0);
    check("R11 busy held without ticks", int'(busy), 1);
    tick = 1'b1;
    j = 48;
    while (busy && j < 2000) begin @(negedge clk); j++; end
    check("R11 stretched frame length", j, 200);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_formats();
    t_enable();
    t_break_idle();
    t_break_mid();
    t_abort();
    t_fmt_mid();
    t_tick();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog all requirements actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule